// File: doc/BRIEF.md
# Manchester Telegram Slave Serial Interface

This block is the serial front end of a field-bus slave. It watches a sampled receive line that has already been demodulated to logic levels and decodes Manchester-II request telegrams from it. It checks the structure of each telegram and the timing of every bit. A request that passes every check has its payload written into a receive register, and the block pulses a one-cycle receive strobe for the downstream controller.

The controller may then answer. It places a response nibble on the transmit register and raises a transmit request. The block sends the answer as a Manchester-II bit stream on a line-driver enable output.

All receive and transmit activity depends on a slave-mode input. While that input is low, the block stays idle and keeps its outputs inactive.

Top module: `mtel_slave_uart`

## Requirements
- R1: After reset, `rx_strobe`, `tx_out` and `tx_busy` are 0 and `rx_data` is all zeros.
- R2: The receive line idles high. A bit of value b is sent as level b for the first half of `BIT_CYC` cycles and level ~b for the second half. A request has 14 bits sent in this order: a start bit of 0, 11 data bits with the LSB first, a parity bit, and an end bit of 1. When a request is valid, `rx_data` takes the 11 data bits.
- R3: Each accepted request causes exactly one `rx_strobe` pulse, and that pulse is one clock cycle wide.
- R4: A request is discarded with no strobe if its start bit is not 0, if its end bit is not 1, or if the 11 data bits plus the parity bit hold an odd number of ones.
- R5: A bit whose first and second halves have the same level has no mid-bit transition. Such a bit is a timing error, and the whole request is discarded with no strobe.
- R6: While `slave_mode` is 0, no request is accepted and `tx_req` is ignored. Starting one cycle later, `tx_out`, `tx_busy` and `rx_strobe` are 0, and any transmission in progress is aborted.
- R7: `tx_req` starts a response only if a strobe has occurred since the last response began. Any other `tx_req` is ignored.
- R8: `tx_req` is ignored until at least `PAUSE_CYC` cycles have passed since the strobe.
- R9: An accepted `tx_req` samples `tx_data`. `tx_busy` is then high for exactly 7 bit periods, during which `tx_out` sends the following bits, each coded as in R2: a start bit of 0, the 4 data bits with the LSB first, an even-parity bit, and an end bit of 1. `tx_out` is 0 whenever `tx_busy` is 0.
- R10: `rx_data` changes only together with a strobe. It keeps its value through rejected requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode | input | 1 | Enables the block when 1 |
| rx_in | input | 1 | Demodulated receive line, asynchronous |
| rx_data | output | RX_DW (11) | Payload of the last valid request |
| rx_strobe | output | 1 | One-cycle pulse for each valid request |
| tx_data | input | TX_DW (4) | Response payload |
| tx_req | input | 1 | Request to send a response |
| tx_out | output | 1 | Manchester-coded line-driver enable |
| tx_busy | output | 1 | High while a response is being sent |

## Verification
The bench sends requests that each fail in one way only: a parity error, a wrong end bit, or a data bit with no mid-bit edge. A receiver that skipped the failing check would strobe and overwrite `rx_data`.

It also issues transmit requests that come too early, with no preceding strobe, or as a second answer to a single strobe. A gate that let any of these through would start `tx_busy`.

It decodes every response bit by bit, including responses for all-zero and all-one payloads. This exposes a swapped half-bit polarity, a reversed bit order, the wrong parity sense or a wrong frame length. Finally, it drops `slave_mode` in the middle of a response, where a block that ignored the mode input would keep driving the line.

// File: rtl/mtel_pkg.sv
package mtel_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_BITS  = 2'd1,
    RX_QUIET = 2'd2
  } rx_state_t;

  localparam int unsigned REQ_OVERHEAD = 3;  // start, parity, end
  localparam int unsigned RSP_OVERHEAD = 3;

endpackage

// File: rtl/mtel_rx_sync.sv
module mtel_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/mtel_rx_deframe.sv
module mtel_rx_deframe
  import mtel_pkg::*;
#(
  parameter int unsigned BIT_CYC = 16,
  parameter int unsigned DW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rx_s,
  output logic          strobe,
  output logic [DW-1:0] data
);

  localparam int unsigned FLEN = DW + REQ_OVERHEAD;
  localparam int unsigned IW   = $clog2(FLEN);
  localparam int unsigned PW   = $clog2(BIT_CYC);
  localparam logic [PW-1:0] PH_A    = PW'(BIT_CYC / 4);
  localparam logic [PW-1:0] PH_B    = PW'(3 * (BIT_CYC / 4));
  localparam logic [PW-1:0] PH_LAST = PW'(BIT_CYC - 1);
  localparam logic [IW-1:0] IX_LAST = IW'(FLEN - 1);

  rx_state_t        st_q, st_d;
  logic [PW-1:0]    ph_q, ph_d;
  logic [PW-1:0]    qc_q, qc_d;
  logic [IW-1:0]    ix_q, ix_d;
  logic             sa_q, sa_d;
  logic             prev_q;
  logic [FLEN-2:0]  frm_q, frm_d;
  logic             stb_q, stb_d;
  logic [DW-1:0]    dat_q, dat_d;
  logic             good;

  // frame accepted when end bit is 1, start bit 0, data+parity even
  assign good = sa_q && !frm_q[0] && !(^frm_q[DW+1:1]);

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    qc_d  = qc_q;
    ix_d  = ix_q;
    sa_d  = sa_q;
    frm_d = frm_q;
    dat_d = dat_q;
    stb_d = 1'b0;
    if (!en) begin
      st_d = RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          if (prev_q && !rx_s) begin
            st_d = RX_BITS;
            ph_d = '0;
            ix_d = '0;
          end
        end
        RX_BITS: begin
          ph_d = ph_q + 1'b1;
          if (ph_q == PH_A) sa_d = rx_s;
          if (ph_q == PH_B) begin
            if (rx_s == sa_q) begin
              st_d = RX_QUIET;            // no mid-bit edge
              qc_d = '0;
            end else if (ix_q == '0 && sa_q) begin
              st_d = RX_QUIET;            // start bit not 0
              qc_d = '0;
            end else if (ix_q == IX_LAST) begin
              st_d = RX_QUIET;
              qc_d = '0;
              if (good) begin
                stb_d = 1'b1;
                dat_d = frm_q[DW:1];
              end
            end else begin
              frm_d[ix_q] = sa_q;
            end
          end
          if (ph_q == PH_LAST) begin
            ph_d = '0;
            ix_d = ix_q + 1'b1;
          end
        end
        RX_QUIET: begin
          if (!rx_s)                 qc_d = '0;
          else if (qc_q == PH_LAST)  st_d = RX_IDLE;
          else                       qc_d = qc_q + 1'b1;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      qc_q   <= '0;
      ix_q   <= '0;
      sa_q   <= 1'b0;
      prev_q <= 1'b1;
      frm_q  <= '0;
      stb_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      qc_q   <= qc_d;
      ix_q   <= ix_d;
      sa_q   <= sa_d;
      prev_q <= rx_s;
      frm_q  <= frm_d;
      stb_q  <= stb_d;
      dat_q  <= dat_d;
    end
  end

  assign strobe = stb_q;
  assign data   = dat_q;

endmodule

// File: rtl/mtel_resp_gate.sv
module mtel_resp_gate #(
  parameter int unsigned PAUSE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic strobe,
  input  logic tx_req,
  input  logic tx_busy,
  output logic accept,
  output logic armed,
  output logic pause_done
);

  localparam int unsigned CW = $clog2(PAUSE_CYC + 1);
  localparam logic [CW-1:0] CNT_END = CW'(PAUSE_CYC);

  logic          arm_q, arm_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done;

  assign done   = (cnt_q == CNT_END);
  assign accept = en && arm_q && done && tx_req && !tx_busy;

  always_comb begin
    arm_d = arm_q;
    cnt_d = cnt_q;
    if (!en) begin
      arm_d = 1'b0;
    end else if (strobe) begin
      arm_d = 1'b1;
      cnt_d = '0;
    end else if (accept) begin
      arm_d = 1'b0;
    end else if (arm_q && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

  assign armed      = arm_q;
  assign pause_done = done;

endmodule

// File: rtl/mtel_tx_frame.sv
module mtel_tx_frame
  import mtel_pkg::*;
#(
  parameter int unsigned BIT_CYC = 16,
  parameter int unsigned DW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          line
);

  localparam int unsigned FLEN = DW + RSP_OVERHEAD;
  localparam int unsigned IW   = $clog2(FLEN);
  localparam int unsigned PW   = $clog2(BIT_CYC);
  localparam logic [PW-1:0] PH_HALF = PW'(BIT_CYC / 2);
  localparam logic [PW-1:0] PH_LAST = PW'(BIT_CYC - 1);
  localparam logic [IW-1:0] IX_LAST = IW'(FLEN - 1);

  logic [FLEN-1:0] sh_q, sh_d;
  logic [IW-1:0]   ix_q, ix_d;
  logic [PW-1:0]   ph_q, ph_d;
  logic            bz_q, bz_d;
  logic            ln_q, ln_d;

  always_comb begin
    sh_d = sh_q;
    ix_d = ix_q;
    ph_d = ph_q;
    bz_d = bz_q;
    if (!en) begin
      bz_d = 1'b0;
    end else if (load) begin
      sh_d = {1'b1, ^data, data, 1'b0};
      ix_d = '0;
      ph_d = '0;
      bz_d = 1'b1;
    end else if (bz_q) begin
      ph_d = ph_q + 1'b1;
      if (ph_q == PH_LAST) begin
        ph_d = '0;
        if (ix_q == IX_LAST) begin
          bz_d = 1'b0;
        end else begin
          ix_d = ix_q + 1'b1;
          sh_d = sh_q >> 1;
        end
      end
    end
    ln_d = bz_d && ((ph_d < PH_HALF) ? sh_d[0] : !sh_d[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ix_q <= '0;
      ph_q <= '0;
      bz_q <= 1'b0;
      ln_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      ix_q <= ix_d;
      ph_q <= ph_d;
      bz_q <= bz_d;
      ln_q <= ln_d;
    end
  end

  assign busy = bz_q;
  assign line = ln_q;

endmodule

// File: rtl/mtel_slave_uart.sv
module mtel_slave_uart #(
  parameter int unsigned BIT_CYC     = 16,
  parameter int unsigned RX_DW       = 11,
  parameter int unsigned TX_DW       = 4,
  parameter int unsigned PAUSE_CYC   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             rx_in,
  output logic [RX_DW-1:0] rx_data,
  output logic             rx_strobe,
  input  logic [TX_DW-1:0] tx_data,
  input  logic             tx_req,
  output logic             tx_out,
  output logic             tx_busy
);

  logic rst_meta, rst_s;
  logic rx_s;
  logic accept_w, armed_w, pause_done_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  mtel_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s), .d(rx_in), .q(rx_s)
  );

  mtel_rx_deframe #(.BIT_CYC(BIT_CYC), .DW(RX_DW)) u_rx (
    .clk(clk), .rst_n(rst_s), .en(slave_mode), .rx_s(rx_s),
    .strobe(rx_strobe), .data(rx_data)
  );

  mtel_resp_gate #(.PAUSE_CYC(PAUSE_CYC)) u_gate (
    .clk(clk), .rst_n(rst_s), .en(slave_mode), .strobe(rx_strobe),
    .tx_req(tx_req), .tx_busy(tx_busy), .accept(accept_w),
    .armed(armed_w), .pause_done(pause_done_w)
  );

  mtel_tx_frame #(.BIT_CYC(BIT_CYC), .DW(TX_DW)) u_tx (
    .clk(clk), .rst_n(rst_s), .en(slave_mode), .load(accept_w),
    .data(tx_data), .busy(tx_busy), .line(tx_out)
  );

endmodule

// File: rtl/mtel_slave_uart_chk.sv
module mtel_slave_uart_chk #(
  parameter int unsigned BIT_CYC = 16,
  parameter int unsigned RX_DW   = 11,
  parameter int unsigned TX_DW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slave_mode,
  input logic [RX_DW-1:0] rx_data,
  input logic             rx_strobe,
  input logic             tx_out,
  input logic             tx_busy,
  input logic             armed,
  input logic             pause_done
);

  localparam int unsigned RSP_CYC = (TX_DW + 3) * BIT_CYC;

  int unsigned blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blen <= 0;
    else if (tx_busy) blen <= blen + 1;
    else              blen <= 0;
  end

  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> !rx_strobe);

  p_master_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !slave_mode |=> (!tx_out && !tx_busy && !rx_strobe));

  p_start_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(armed));

  p_start_paused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(pause_done));

  p_resp_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_busy) && slave_mode && $past(slave_mode)) |-> (blen == RSP_CYC));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_out);

  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_strobe |-> $stable(rx_data));

endmodule

bind mtel_slave_uart mtel_slave_uart_chk #(
  .BIT_CYC(BIT_CYC), .RX_DW(RX_DW), .TX_DW(TX_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .rx_data(rx_data),
  .rx_strobe(rx_strobe), .tx_out(tx_out), .tx_busy(tx_busy),
  .armed(armed_w), .pause_done(pause_done_w)
);

// File: tb/mtel_slave_uart_test.sv
`timescale 1ns/1ps
module mtel_slave_uart_test;

  localparam int BIT   = 16;
  localparam int HALF  = BIT / 2;
  localparam int QTR   = BIT / 4;
  localparam int RDW   = 11;
  localparam int TDW   = 4;
  localparam int FLEN  = RDW + 3;
  localparam int TLEN  = TDW + 3;
  localparam int PAUSE = 64;

  logic           clk = 1'b0;
  logic           rst_n, slave_mode, rx_in, tx_req;
  logic [TDW-1:0] tx_data;
  logic [RDW-1:0] rx_data;
  logic           rx_strobe, tx_out, tx_busy;

  int checks = 0;
  int errors = 0;
  int stb_hi = 0;
  int stb_rise = 0;
  logic stb_prev = 1'b0;
  bit finished = 1'b0;
  logic [RDW-1:0] last_good;

  always #5 clk = ~clk;

  mtel_slave_uart #(.BIT_CYC(BIT), .RX_DW(RDW), .TX_DW(TDW), .PAUSE_CYC(PAUSE)) uut (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .rx_in(rx_in),
    .rx_data(rx_data), .rx_strobe(rx_strobe), .tx_data(tx_data),
    .tx_req(tx_req), .tx_out(tx_out), .tx_busy(tx_busy)
  );

  always @(negedge clk) begin
    if (rx_strobe) stb_hi++;
    if (rx_strobe && !stb_prev) stb_rise++;
    stb_prev = rx_strobe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FLEN-1:0] req_frame(input logic [RDW-1:0] d);
    return {1'b1, ^d, d, 1'b0};
  endfunction

  function automatic logic [TLEN-1:0] rsp_frame(input logic [TDW-1:0] d);
    return {1'b1, ^d, d, 1'b0};
  endfunction

  // flat_bit >= 0 sends that bit without its mid-bit edge
  task automatic send(input logic [FLEN-1:0] f, input int flat_bit);
    for (int i = 0; i < FLEN; i++) begin
      repeat (HALF) begin @(negedge clk); rx_in = f[i]; end
      repeat (HALF) begin @(negedge clk); rx_in = (i == flat_bit) ? f[i] : ~f[i]; end
    end
    @(negedge clk); rx_in = 1'b1;
    repeat (2*BIT) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [TDW-1:0] t);
    @(negedge clk); tx_data = t; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic expect_ignored(input logic [TDW-1:0] t, input string req);
    bit seen = 1'b0;
    pulse_req(t);
    repeat (2*BIT) begin
      if (tx_busy || tx_out) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, req, "tx_req ignored", 32'(seen), 32'd0);
  endtask

  task automatic respond_check(input logic [TDW-1:0] t);
    logic [TLEN-1:0] exp_f;
    logic [TLEN-1:0] got_a, got_b;
    exp_f = rsp_frame(t);
    pulse_req(t);
    chk(tx_busy === 1'b1, "R8", "request after pause accepted", 32'(tx_busy), 32'd1);
    for (int b = 0; b < TLEN; b++) begin
      repeat (QTR) @(negedge clk);
      got_a[b] = tx_out;
      repeat (HALF) @(negedge clk);
      got_b[b] = tx_out;
      repeat (QTR) @(negedge clk);
    end
    chk(got_a === exp_f && got_b === ~exp_f, "R9", "response first/second halves",
        32'({got_a, got_b}), 32'({exp_f, ~exp_f}));
    chk(tx_busy === 1'b0 && tx_out === 1'b0, "R9", "busy ends after 7 bits",
        32'({tx_busy, tx_out}), 32'd0);
  endtask

  task automatic valid_round(input logic [RDW-1:0] d, input logic [TDW-1:0] t);
    int r0 = stb_rise;
    send(req_frame(d), -1);
    chk(stb_rise == r0 + 1, "R3", "one strobe per request", 32'(stb_rise - r0), 32'd1);
    chk(rx_data === d, "R2", "rx_data payload", 32'(rx_data), 32'(d));
    chk(stb_hi == stb_rise, "R3", "strobe width one cycle", 32'(stb_hi), 32'(stb_rise));
    last_good = d;
    expect_ignored(t, "R8");
    repeat (PAUSE) @(negedge clk);
    respond_check(t);
    expect_ignored(~t, "R7");
  endtask

  task automatic bad_round(input logic [FLEN-1:0] f, input int flat, input string req);
    int r0 = stb_rise;
    send(f, flat);
    chk(stb_rise == r0, req, "no strobe on bad request", 32'(stb_rise - r0), 32'd0);
    chk(rx_data === last_good, "R10", "rx_data kept", 32'(rx_data), 32'(last_good));
  endtask

  initial begin
    logic [FLEN-1:0] f;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; slave_mode = 1'b1; rx_in = 1'b1; tx_req = 1'b0; tx_data = '0;
    repeat (5) @(negedge clk);
    chk(rx_strobe === 1'b0 && tx_out === 1'b0 && tx_busy === 1'b0, "R1",
        "outputs in reset", 32'({rx_strobe, tx_out, tx_busy}), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_data === '0, "R1", "rx_data after reset", 32'(rx_data), 32'd0);
    last_good = '0;

    expect_ignored(4'h9, "R7");

    valid_round('0, 4'h0);
    valid_round('1, 4'hF);
    for (int k = 0; k < 6; k++)
      valid_round(RDW'($urandom), TDW'($urandom));

    f = req_frame(11'h2A5); f[RDW+1] = ~f[RDW+1];
    bad_round(f, -1, "R4");
    f = req_frame(11'h13C); f[FLEN-1] = 1'b0;
    bad_round(f, -1, "R4");
    bad_round(req_frame(11'h555), 5, "R5");
    bad_round(req_frame(11'h0F0), 1, "R5");

    slave_mode = 1'b0;
    bad_round(req_frame(11'h321), -1, "R6");
    expect_ignored(4'h6, "R6");
    slave_mode = 1'b1;
    repeat (2*BIT) @(negedge clk);

    valid_round(11'h7A1, 4'hA);

    send(req_frame(11'h1B4), -1);
    last_good = 11'h1B4;
    repeat (PAUSE) @(negedge clk);
    pulse_req(4'h5);
    repeat (20) @(negedge clk);
    chk(tx_busy === 1'b1, "R9", "busy mid response", 32'(tx_busy), 32'd1);
    slave_mode = 1'b0;
    @(negedge clk);
    chk(tx_busy === 1'b0 && tx_out === 1'b0, "R6", "abort on master mode",
        32'({tx_busy, tx_out}), 32'd0);
    slave_mode = 1'b1;
    repeat (BIT) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule